// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A single 32-pin general-purpose I/O bank with a small memory-mapped register interface. Software drives an output data word and an output enable word for the pad ring. It reads the pin levels through a two-flop synchronizer. Every pin also has its own interrupt detector. Per-pin bits pick edge or level sensing and the active polarity. A detected event latches into a sticky status bit, and all enabled pending bits are ORed onto one interrupt line.

Each control word sits at a group base address, with groups 0x10 apart. A write to base+0x0 loads the whole word. A write to base+0x4 ORs the data into it. A write to base+0x8 clears every bit that is 1 in the data. This lets software change single pins without a read-modify-write. Status bits can only be cleared, and only through the clear alias.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0 and `dout_o`, `oe_o` and `irq_o` are 0.
- R2: The group layout is: output data 0x00, input data 0x10, output enable 0x20, interrupt select 0x30, interrupt enable 0x40, sense level 0x50, polarity 0x60, status 0x70. A write to base+0x0 of a control group replaces its value. A read at base+0x0, +0x4 or +0x8 returns the group value.
- R3: A write to base+0x4 ORs the written data into the register.
- R4: A write to base+0x8 clears the register bits that are 1 in the written data.
- R5: The input data group returns the pin values two clock edges after they are applied to `pins_i`. Writes to it are ignored.
- R6: With the level bit 0 and the polarity bit 1, a 0-to-1 change of a pin sets its status bit three edges after the change is applied, and a 1-to-0 change does not.
- R7: With the level bit 0 and the polarity bit 0, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R8: With the level bit 1, status is set on every cycle in which the pin equals the polarity bit (1 = high, 0 = low). A clear-alias write therefore has no lasting effect until the level goes inactive.
- R9: A pin whose interrupt select bit is 0 never sets its status bit.
- R10: Status bits are cleared only by a 1 written to status base+0x8. Writes to base+0x0 and base+0x4 of the status group change nothing.
- R11: `irq_o` is 1 exactly when some bit is 1 in both the status and the interrupt enable registers.
- R12: When a detected event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R13: `dout_o` and `oe_o` show the output data and output enable registers. Offsets other than 0x0, 0x4 and 0x8 within a group, and group bases at 0x80 and above, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address (group in [7:4], alias offset in [3:0]) |
| we_i | input | 1 | Write strobe, committed on the rising clock edge |
| wdata_i | input | 32 | Write data or bit mask |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pins_i | input | 32 | Asynchronous pin levels from the pads |
| dout_o | output | 32 | Output data to the pads |
| oe_o | output | 32 | Output enable to the pads |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The bench times a status clear so that it lands in the same cycle as a fresh rising edge. A design that let the clear win would drop that interrupt and show status 0 where 1 is expected. It holds a level source active across a clear. A design that latched level events only once would read 0 after the clear and not the expected bit. It writes the status group through its load and set aliases. Any design that let those writes through would wipe or invent pending bits. It also toggles a pin whose select bit is off, which exposes a detector that ignores the select. A behavioural model built on a pin-history queue is compared with all outputs on every cycle, so off-by-one synchronizer depths show up as mismatches.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_W   = 32;
  localparam int unsigned BUS_AW  = 8;
  localparam int unsigned OFS_W   = 4;
  localparam int unsigned NUM_GRP = 8;

  // group index = addr[7:4]; detector and pads depend on this order only via names
  localparam int unsigned G_DOUT = 0;
  localparam int unsigned G_DIN  = 1;
  localparam int unsigned G_OE   = 2;
  localparam int unsigned G_SEL  = 3;
  localparam int unsigned G_EN   = 4;
  localparam int unsigned G_LVL  = 5;
  localparam int unsigned G_POL  = 6;
  localparam int unsigned G_STAT = 7;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } reg_op_e;

  function automatic reg_op_e decode_op(input logic [OFS_W-1:0] ofs);
    case (ofs)
      4'h0:    return OP_LOAD;
      4'h4:    return OP_SET;
      4'h8:    return OP_CLR;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
  import gpio_pkg::*;
#(
  parameter int unsigned W = PIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (wr_i) begin
      unique case (op_i)
        OP_LOAD: q_q <= wdata_i;
        OP_SET:  q_q <= q_q | wdata_i;
        OP_CLR:  q_q <= q_q & ~wdata_i;
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= pins_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] hit;
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic act_now, act_was;
    // polarity folds rising/high and falling/low into one active sense
    assign act_now = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign act_was = pol_i[i] ? prev_i[i] : ~prev_i[i];
    assign hit[i]  = sel_i[i] & (lvl_i[i] ? act_now : (act_now & ~act_was));
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS      = PIN_W,
  parameter int unsigned ADDR_W      = BUS_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] dout_o,
  output logic [N_PINS-1:0] oe_o,
  output logic              irq_o
);
  localparam int unsigned GRP_AW = ADDR_W - OFS_W;
  localparam int unsigned GRP_IW = $clog2(NUM_GRP);

  logic [GRP_AW-1:0] grp;
  logic [OFS_W-1:0]  ofs;
  reg_op_e           op;
  logic              grp_ok;
  logic [N_PINS-1:0] grp_val [NUM_GRP];
  logic [N_PINS-1:0] sync_w, prev_w, stat_w, clr_w;
  logic [N_PINS-1:0] sel_w, en_w, lvl_w, pol_w;

  assign grp    = addr_i[ADDR_W-1:OFS_W];
  assign ofs    = addr_i[OFS_W-1:0];
  assign op     = decode_op(ofs);
  assign grp_ok = (32'(grp) < NUM_GRP);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == G_DIN) begin : g_din
      assign grp_val[g] = sync_w;
    end else if (g == G_STAT) begin : g_stat
      assign grp_val[g] = stat_w;
    end else begin : g_ctrl
      logic wr;
      assign wr = we_i && (op != OP_NONE) && (grp == GRP_AW'(g));
      gpio_ctrl_reg #(.W(N_PINS)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr),
        .op_i   (op),
        .wdata_i(wdata_i),
        .q_o    (grp_val[g])
      );
    end
  end

  assign sel_w  = grp_val[G_SEL];
  assign en_w   = grp_val[G_EN];
  assign lvl_w  = grp_val[G_LVL];
  assign pol_w  = grp_val[G_POL];
  assign dout_o = grp_val[G_DOUT];
  assign oe_o   = grp_val[G_OE];

  assign clr_w = (we_i && op == OP_CLR && grp == GRP_AW'(G_STAT)) ? wdata_i : '0;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .sync_o(sync_w),
    .prev_o(prev_w)
  );

  gpio_irq_detect #(.W(N_PINS)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_w),
    .prev_i(prev_w),
    .sel_i (sel_w),
    .lvl_i (lvl_w),
    .pol_i (pol_w),
    .clr_i (clr_w),
    .stat_o(stat_w)
  );

  always_comb begin
    rdata_o = '0;
    if (grp_ok && op != OP_NONE) rdata_o = grp_val[grp[GRP_IW-1:0]];
  end

  assign irq_o = |(stat_w & en_w);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS = PIN_W,
  parameter int unsigned ADDR_W = BUS_AW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] dout_o,
  input logic [N_PINS-1:0] oe_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] stat_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] sel_q
);
  localparam logic [ADDR_W-1:0] STAT_CLR_A = ADDR_W'((G_STAT << OFS_W) | 8);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (dout_o == '0 && oe_o == '0 && !irq_o);
    end
  end

  assert_stat_clear_path_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(stat_q) & ~stat_q)) |-> ($past(we_i) && $past(addr_i) == STAT_CLR_A));

  assert_clear_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_q) & ~stat_q & ~$past(wdata_i)) == '0));

  assert_sel_gates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0));

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0 && stat_q != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .dout_o (dout_o),
  .oe_o   (oe_o),
  .irq_o  (irq_o),
  .stat_q (stat_w),
  .en_q   (en_w),
  .sel_q  (sel_w)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pins_i = '0;
  logic [31:0] dout_o, oe_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R1";
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pins_i(pins_i),
    .dout_o(dout_o), .oe_o(oe_o), .irq_o(irq_o)
  );

  // reference model
  logic [31:0] m_dout, m_oe, m_sel, m_en, m_lvl, m_pol, m_stat;
  logic [31:0] hist [$];

  function automatic logic [31:0] upd(input logic [31:0] cur, input logic [3:0] o,
                                      input logic [31:0] d);
    if (o == 4'h0) return d;
    if (o == 4'h4) return cur | d;
    if (o == 4'h8) return cur & ~d;
    return cur;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (!(a[3:0] == 4'h0 || a[3:0] == 4'h4 || a[3:0] == 4'h8)) return '0;
    case (a[7:4])
      4'd0: return m_dout;
      4'd1: return hist[1];
      4'd2: return m_oe;
      4'd3: return m_sel;
      4'd4: return m_en;
      4'd5: return m_lvl;
      4'd6: return m_pol;
      4'd7: return m_stat;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_dout, m_oe, m_sel, m_en, m_lvl, m_pol, m_stat} = '0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev, clr;
      ev = '0;
      clr = '0;
      for (int b = 0; b < 32; b++) begin
        logic now_v, old_v;
        now_v = hist[1][b];
        old_v = hist[2][b];
        if (m_sel[b]) begin
          if (m_lvl[b]) ev[b] = (now_v == m_pol[b]);
          else if (m_pol[b]) ev[b] = now_v && !old_v;
          else ev[b] = !now_v && old_v;
        end
      end
      if (we_i) begin
        case (addr_i[7:4])
          4'd0: m_dout = upd(m_dout, addr_i[3:0], wdata_i);
          4'd2: m_oe   = upd(m_oe,   addr_i[3:0], wdata_i);
          4'd3: m_sel  = upd(m_sel,  addr_i[3:0], wdata_i);
          4'd4: m_en   = upd(m_en,   addr_i[3:0], wdata_i);
          4'd5: m_lvl  = upd(m_lvl,  addr_i[3:0], wdata_i);
          4'd6: m_pol  = upd(m_pol,  addr_i[3:0], wdata_i);
          4'd7: if (addr_i[3:0] == 4'h8) clr = wdata_i;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~clr) | ev;
      hist.push_front(pins_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({cur_tag, " rdata"}, rdata_o, m_read(addr_i));
      chk({cur_tag, " irq"},   {31'b0, irq_o}, {31'b0, |(m_stat & m_en)});
      chk({cur_tag, " dout"},  dout_o, m_dout);
      chk({cur_tag, " oe"},    oe_o, m_oe);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #2;
    we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk_i); #2;
    addr_i = a;
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(posedge clk_i); #2;
    pins_i = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired got=%h exp=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs during and after reset
    repeat (3) @(posedge clk_i);
    #3 chk("R1 dout in reset", dout_o, 32'h0);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    @(posedge clk_i); #2 rst_ni = 1'b1;
    rd_chk(8'h00, 32'h0, "R1 dout reg after reset");
    rd_chk(8'h70, 32'h0, "R1 status after reset");
    chk("R1 oe after reset", oe_o, 32'h0);

    cur_tag = "R2";
    wr(8'h00, 32'hA5A5_0F0F);
    rd_chk(8'h00, 32'hA5A5_0F0F, "R2 load readback");
    chk("R13 dout_o follows reg", dout_o, 32'hA5A5_0F0F);

    cur_tag = "R3";
    wr(8'h04, 32'h0000_F000);
    rd_chk(8'h04, 32'hA5A5_FF0F, "R3 set alias");

    cur_tag = "R4";
    wr(8'h08, 32'hA500_0000);
    rd_chk(8'h00, 32'h00A5_FF0F, "R4 clear alias");

    cur_tag = "R13";
    wr(8'h20, 32'hFFFF_0000);
    #1 chk("R13 oe_o follows reg", oe_o, 32'hFFFF_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h0C, 32'h0, "R13 unused offset reads 0");
    rd_chk(8'h00, 32'h00A5_FF0F, "R13 unused offset write ignored");
    rd_chk(8'h80, 32'h0, "R13 unmapped group reads 0");

    cur_tag = "R5";
    set_pins(32'h1234_5678);
    idle(3);
    rd_chk(8'h10, 32'h1234_5678, "R5 input data");
    wr(8'h10, 32'h0);
    rd_chk(8'h10, 32'h1234_5678, "R5 input write ignored");
    set_pins(32'h0);
    idle(4);

    cur_tag = "R6";
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h60, 32'h0000_0001);
    rd_chk(8'h70, 32'h0, "R6 no event before edge");
    set_pins(32'h1);
    idle(4);
    rd_chk(8'h70, 32'h1, "R6 rising edge latched");

    cur_tag = "R7";
    set_pins(32'h3);
    idle(4);
    rd_chk(8'h70, 32'h1, "R7 rising ignored in falling mode");
    set_pins(32'h1);
    idle(4);
    rd_chk(8'h70, 32'h3, "R7 falling edge latched");

    cur_tag = "R11";
    #1 chk("R11 irq low with enable 0", {31'b0, irq_o}, 32'h0);
    wr(8'h40, 32'h2);
    #1 chk("R11 irq high when enabled", {31'b0, irq_o}, 32'h1);
    wr(8'h78, 32'h2);
    #1 chk("R11 irq low after clear", {31'b0, irq_o}, 32'h0);

    cur_tag = "R10";
    wr(8'h70, 32'h0);
    wr(8'h74, 32'hFFFF_0000);
    rd_chk(8'h70, 32'h1, "R10 status load/set ignored");

    cur_tag = "R8";
    wr(8'h64, 32'h0000_0010);
    wr(8'h54, 32'h0000_0030);
    idle(2);
    rd_chk(8'h70, 32'h21, "R8 low level active");
    set_pins(32'h11);
    idle(4);
    rd_chk(8'h70, 32'h31, "R8 high level active");
    wr(8'h78, 32'h30);
    rd_chk(8'h70, 32'h31, "R8 clear ineffective while level holds");
    set_pins(32'h21);
    idle(4);
    wr(8'h78, 32'h30);
    rd_chk(8'h70, 32'h01, "R8 clear works once level inactive");

    cur_tag = "R9";
    wr(8'h38, 32'h100);
    set_pins(32'h121);
    idle(4);
    set_pins(32'h21);
    idle(4);
    rd_chk(8'h70, 32'h01, "R9 unselected pin ignored");
    wr(8'h34, 32'h100);
    set_pins(32'h121);
    idle(4);
    set_pins(32'h21);
    idle(4);
    rd_chk(8'h70, 32'h101, "R9 selected pin detects");

    cur_tag = "R12";
    wr(8'h78, 32'h101);
    set_pins(32'h20);
    idle(4);
    rd_chk(8'h70, 32'h0, "R12 status cleared before race");
    set_pins(32'h21);
    @(posedge clk_i);
    wr(8'h78, 32'h1);
    rd_chk(8'h70, 32'h1, "R12 event beats same-cycle clear");
    wr(8'h44, 32'h1);
    #1 chk("R11 irq from pin0", {31'b0, irq_o}, 32'h1);

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule